// File: doc/BRIEF.md
# Demand-Actuated Highway and Side-Road Signal Controller

This block drives the red, amber and green lamps for a crossing where a busy highway meets a lightly used side road. The highway keeps right of way by default. A vehicle detector on the side road is the only thing that can take that right of way away, and the highway still gets a guaranteed minimum green each time it regains right of way. The side road gets a green that lasts while vehicles keep coming, with an upper limit on its length.

The block runs from a fast reference clock. It builds its own one-second tick by chaining two decimal counters. It also shows the seconds left in the current timed phase as two BCD digits. All control and status pins are plain levels. There is no streaming interface, so no valid/ready handshake applies. Phase lengths and the divider ratios are parameters: 60 s minimum highway green, 20 s maximum side green, 5 s amber, and a divide-by-100 built from two stages of 10.

Top module: `tlc_ctrl`

## Requirements
- R1: With no sensed side-road demand, the highway stays green and the side road stays red for as long as the demand stays absent. The highway leaves green only on a tick at which demand is seen and its minimum timer has run out.
- R2: Each time the highway turns green, it stays green for at least MAIN_MIN_S ticks (60), even if demand is present the whole time.
- R3: While demand persists, the side-road green ends after SIDE_MAX_S ticks (20) and amber follows.
- R4: Phases run in the fixed order highway green, highway amber, side green, side amber, then highway green again. Each amber lasts CLEAR_S ticks (5).
- R5: If demand is absent at a tick during side green, side amber starts at that tick.
- R6: Each road has exactly one lamp lit at all times. The side road shows red whenever the highway shows green or amber.
- R7: The countdown (tens digit on `secs_tens`, units digit on `secs_units`, each 0 to 9) is loaded with the phase length minus one when a phase starts. It drops by one on each tick and reads 00 in the last second of the phase. In highway green it holds at 00 while waiting for demand.
- R8: The tick occurs once every DIV_LO*DIV_HI clocks, from a units counter that carries into a second counter. Lamps and countdown change only at a tick.
- R9: The sensor passes through two synchronizing flops and is looked at only on tick cycles. A pulse that comes and goes between ticks has no effect.
- R10: Synchronous reset gives highway green, side red and a countdown of MAIN_MIN_S-1 (59).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| side_car | input | 1 | Side-road vehicle detector, asynchronous |
| main_red | output | 1 | Highway red lamp |
| main_amber | output | 1 | Highway amber lamp |
| main_green | output | 1 | Highway green lamp |
| side_red | output | 1 | Side-road red lamp |
| side_amber | output | 1 | Side-road amber lamp |
| side_green | output | 1 | Side-road green lamp |
| secs_tens | output | 4 | Countdown tens digit, BCD |
| secs_units | output | 4 | Countdown units digit, BCD |

## Verification
The bench builds the block with DIV_LO=2 and DIV_HI=3, so one second is six clocks. The phase lengths stay at 60, 20 and 5 seconds. This lets 240 seconds of traffic fit in about 1500 clocks, covering an idle hold, a side green cut off by the limit, a full minimum green under constant demand, and a side green ended early by a demand drop. A six-clock second leaves room for a one-clock sensor pulse to pass through the synchronizer and clear again before the tick, both right after highway green starts and while the highway waits at 00.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO  = 2'd0,
    PH_MAIN_CLR = 2'd1,
    PH_SIDE_GO  = 2'd2,
    PH_SIDE_CLR = 2'd3
  } phase_t;

  // Two-digit BCD of a value in 0..99
  function automatic logic [7:0] to_bcd(input int v);
    logic [3:0] t;
    logic [3:0] u;
    t = 4'(v / 10);
    u = 4'(v % 10);
    return {t, u};
  endfunction

endpackage

// File: rtl/tlc_tick_gen.sv
module tlc_tick_gen #(
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int LW = (DIV_LO > 1) ? $clog2(DIV_LO) : 1;
  localparam int HW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam logic [LW-1:0] LO_TOP = LW'(DIV_LO - 1);
  localparam logic [HW-1:0] HI_TOP = HW'(DIV_HI - 1);

  logic [LW-1:0] lo_q;
  logic [HW-1:0] hi_q;
  logic          lo_carry;

  assign lo_carry = (lo_q == LO_TOP);
  assign tick     = lo_carry && (hi_q == HI_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
    end else if (lo_carry) begin
      lo_q <= '0;
    end else begin
      lo_q <= lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
    end else if (lo_carry) begin
      if (hi_q == HI_TOP) hi_q <= '0;
      else                hi_q <= hi_q + 1'b1;
    end
  end

  // R8: a tick is a single-cycle pulse when the ratio exceeds one
  a_r8_tick_single: assert property (@(posedge clk) disable iff (rst)
    ((DIV_LO * DIV_HI > 1) && tick) |=> !tick);

endmodule

// File: rtl/tlc_sensor_sync.sv
module tlc_sensor_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], raw};
  end

  assign sync = sh_q[STAGES-1];

  // R9: synchronized level follows the raw input STAGES clocks later
  a_r9_sync_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(sync) |-> $past(raw, STAGES));

endmodule

// File: rtl/tlc_bcd_down.sv
module tlc_bcd_down #(
  parameter logic [7:0] RST_VAL = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       dec,
  output logic [3:0] tens,
  output logic [3:0] units,
  output logic       zero
);
  logic [3:0] tens_q;
  logic [3:0] units_q;

  assign tens  = tens_q;
  assign units = units_q;
  assign zero  = (tens_q == 4'd0) && (units_q == 4'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      {tens_q, units_q} <= RST_VAL;
    end else if (load) begin
      {tens_q, units_q} <= load_val;
    end else if (dec && !zero) begin
      if (units_q == 4'd0) begin
        units_q <= 4'd9;
        tens_q  <= tens_q - 4'd1;
      end else begin
        units_q <= units_q - 4'd1;
      end
    end
  end

  // R7: both digits always hold legal BCD
  a_r7_bcd_legal: assert property (@(posedge clk) disable iff (rst)
    (tens_q <= 4'd9) && (units_q <= 4'd9));

  // R7: a count at zero does not wrap on a decrement
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (dec && zero && !load) |=> (tens_q == 4'd0 && units_q == 4'd0));

endmodule

// File: rtl/tlc_ctrl.sv
module tlc_ctrl #(
  parameter int DIV_LO     = 10,
  parameter int DIV_HI     = 10,
  parameter int MAIN_MIN_S = 60,
  parameter int SIDE_MAX_S = 20,
  parameter int CLEAR_S    = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       side_car,
  output logic       main_red,
  output logic       main_amber,
  output logic       main_green,
  output logic       side_red,
  output logic       side_amber,
  output logic       side_green,
  output logic [3:0] secs_tens,
  output logic [3:0] secs_units
);
  import tlc_pkg::*;

  localparam logic [7:0] MAIN_LD = to_bcd(MAIN_MIN_S - 1);
  localparam logic [7:0] SIDE_LD = to_bcd(SIDE_MAX_S - 1);
  localparam logic [7:0] CLR_LD  = to_bcd(CLEAR_S - 1);

  logic       tick;
  logic       demand;
  logic       t_zero;
  logic       t_load;
  logic       t_dec;
  logic [7:0] t_val;
  phase_t     phase_q;
  phase_t     phase_d;

  tlc_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  tlc_sensor_sync #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw (side_car),
    .sync(demand)
  );

  tlc_bcd_down #(.RST_VAL(MAIN_LD)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(t_val),
    .dec     (t_dec),
    .tens    (secs_tens),
    .units   (secs_units),
    .zero    (t_zero)
  );

  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = MAIN_LD;
    t_dec   = 1'b0;
    if (tick) begin
      unique case (phase_q)
        PH_MAIN_GO: begin
          if (t_zero && demand) begin
            phase_d = PH_MAIN_CLR;
            t_load  = 1'b1;
            t_val   = CLR_LD;
          end else begin
            t_dec = 1'b1;
          end
        end
        PH_MAIN_CLR: begin
          if (t_zero) begin
            phase_d = PH_SIDE_GO;
            t_load  = 1'b1;
            t_val   = SIDE_LD;
          end else begin
            t_dec = 1'b1;
          end
        end
        PH_SIDE_GO: begin
          if (t_zero || !demand) begin
            phase_d = PH_SIDE_CLR;
            t_load  = 1'b1;
            t_val   = CLR_LD;
          end else begin
            t_dec = 1'b1;
          end
        end
        PH_SIDE_CLR: begin
          if (t_zero) begin
            phase_d = PH_MAIN_GO;
            t_load  = 1'b1;
            t_val   = MAIN_LD;
          end else begin
            t_dec = 1'b1;
          end
        end
        default: phase_d = PH_MAIN_GO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_MAIN_GO;
    else     phase_q <= phase_d;
  end

  assign main_green = (phase_q == PH_MAIN_GO);
  assign main_amber = (phase_q == PH_MAIN_CLR);
  assign main_red   = (phase_q == PH_SIDE_GO) || (phase_q == PH_SIDE_CLR);
  assign side_green = (phase_q == PH_SIDE_GO);
  assign side_amber = (phase_q == PH_SIDE_CLR);
  assign side_red   = (phase_q == PH_MAIN_GO) || (phase_q == PH_MAIN_CLR);

  // R6: one lamp per road
  a_r6_main_one_lamp: assert property (@(posedge clk) disable iff (rst)
    $countones({main_red, main_amber, main_green}) == 1);
  a_r6_side_one_lamp: assert property (@(posedge clk) disable iff (rst)
    $countones({side_red, side_amber, side_green}) == 1);
  a_r6_side_red_guard: assert property (@(posedge clk) disable iff (rst)
    (main_green || main_amber) |-> side_red);

  // R1: the highway gives up green only on a tick with demand and expired timer
  a_r1_leave_needs_demand: assert property (@(posedge clk) disable iff (rst)
    $fell(main_green) |-> ($past(tick) && $past(demand) && $past(t_zero)));

  // R8: lamps hold between ticks
  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase_q));

  // R4: amber of the highway is always followed by side green
  a_r4_order: assert property (@(posedge clk) disable iff (rst)
    ($past(main_amber) && $fell(main_amber)) |-> side_green);

endmodule

// File: tb/tlc_ctrl_bench.sv
module tlc_ctrl_bench;
  localparam int DIV_LO = 2;
  localparam int DIV_HI = 3;
  localparam int DIV    = DIV_LO * DIV_HI;
  localparam int SECS   = 240;

  // lamp code {main r,a,g, side r,a,g}
  localparam logic [5:0] L_MG = 6'b001_100;
  localparam logic [5:0] L_MA = 6'b010_100;
  localparam logic [5:0] L_SG = 6'b100_001;
  localparam logic [5:0] L_SA = 6'b100_010;

  typedef struct {
    logic [5:0] lamps;
    logic [7:0] cnt;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic side_car = 1'b0;
  logic main_red, main_amber, main_green, side_red, side_amber, side_green;
  logic [3:0] secs_tens, secs_units;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  tlc_ctrl #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tlc_ctrl (
    .clk       (clk),
    .rst       (rst),
    .side_car  (side_car),
    .main_red  (main_red),
    .main_amber(main_amber),
    .main_green(main_green),
    .side_red  (side_red),
    .side_amber(side_amber),
    .side_green(side_green),
    .secs_tens (secs_tens),
    .secs_units(secs_units)
  );

  function automatic logic [13:0] observed();
    return {main_red, main_amber, main_green, side_red, side_amber, side_green,
            secs_tens, secs_units};
  endfunction

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // pushes n seconds of one phase, counting down from start and holding at 00
  task automatic push_run(input logic [5:0] lamps, input int start, input int n,
                          input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int v;
      v = (start - i < 0) ? 0 : start - i;
      e.lamps = lamps;
      e.cnt   = {4'(v / 10), 4'(v % 10)};
      e.tag   = tag;
      exp_q.push_back(e);
    end
  endtask

  function automatic logic demand_for(input int n);
    return (n >= 71 && n <= 169);
  endfunction

  // driver: expected schedule plus sensor stimulus
  initial begin
    push_run(L_MG, 58, 70, "R1");   // idle hold at 00
    push_run(L_MA, 4, 5, "R4");
    push_run(L_SG, 19, 20, "R3");   // cut off at limit
    push_run(L_SA, 4, 5, "R4");
    push_run(L_MG, 59, 60, "R2");   // full minimum despite demand
    push_run(L_MA, 4, 5, "R4");
    push_run(L_SG, 19, 4, "R7");
    push_run(L_SA, 4, 5, "R5");     // demand dropped
    push_run(L_MG, 59, 60, "R7");
    push_run(L_MG, 0, 6, "R9");     // glitch while waiting

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10", observed(), {L_MG, 8'h59});
    rst = 1'b0;
    for (int n = 1; n <= SECS; n++) begin
      side_car = demand_for(n);
      if (n == 176 || n == 238) begin
        side_car = 1'b1;           // R9 one-clock pulse between ticks
        @(negedge clk);
        side_car = 1'b0;
        repeat (DIV - 1) @(posedge clk);
      end else begin
        repeat (DIV) @(posedge clk);
      end
      @(negedge clk);
    end
  end

  // monitor: R8 stability before each tick, then compare after it
  initial begin
    exp_t prev;
    prev.lamps = L_MG;
    prev.cnt   = 8'h59;
    prev.tag   = "R10";
    wait (!rst);
    for (int n = 1; n <= SECS; n++) begin
      exp_t e;
      repeat (DIV - 1) @(posedge clk);
      @(negedge clk);
      check("R8", observed(), {prev.lamps, prev.cnt});
      @(posedge clk);
      @(negedge clk);
      e = exp_q.pop_front();
      check(e.tag, observed(), {e.lamps, e.cnt});
      check("R6", {13'd0, (main_green || main_amber) ? side_red : 1'b1}, 14'd1);
      prev = e;
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule